// File: doc/BRIEF.md
# FSK Tone Demodulator with Amplitude Carrier Detect

This block sits behind a sampling ADC on the receive side of a half-duplex FSK loop modem. It takes signed samples of a band-limited signal that carries 1200 Hz (mark) and 2200 Hz (space) tones. From these samples it rebuilds the NRZ bit stream at 1200 bit/s. The bits are passed through unchanged, so any character framing is left to a UART downstream. Next to the data it raises a carrier flag. This flag is based on the peak-to-peak swing of the input and switches with hysteresis.

The tone is found by measuring how many samples lie between zero crossings, one measurement per half-cycle. A long half-cycle means mark and a short one means space. The output follows a new tone only after two half-cycle measurements in a row agree. The carrier flag is evaluated once per block of samples. While there is no carrier, the data output rests at mark. While the modem transmits (`rx_en` low), the whole receive path is held in its idle state.

Top module: `fsk_demod_cd`

## Requirements
- R1: Each zero crossing produces a half-cycle interval, counted in valid samples from the previous crossing sample to this one. An interval of at least MARK_MIN (default 25) samples is classed as mark (1), and a shorter one as space (0). A 32-sample half-cycle therefore gives 1 and a 17-sample one gives 0.
- R2: `rx_data` takes a new value only when two consecutive half-cycle intervals give the same class. A single stray half-cycle leaves it unchanged.
- R3: A crossing counts only when the sample moves past the hysteresis band of ±ZC_HYST LSB (default 8). From the negative state, a sample must exceed +8. From the positive state, a sample must fall below −8. Dips of smaller size are ignored.
- R4: At the last sample of each block of 2^WIN_LOG2 (default 64) valid samples, the block's max−min span is compared with two limits. A span above CD_ON (400 LSB, about 120 mV) sets `carrier`. A span below CD_OFF (266 LSB, about 80 mV) clears it. Any span in between leaves `carrier` as it was.
- R5: While `carrier` is 0, `rx_data` is 1.
- R6: While `rx_en` is low, `carrier` is 0 and `rx_data` is 1 from the next clock on, and samples are ignored. After `rx_en` returns high, the crossing, vote and block state start fresh.
- R7: `smp_data` is ignored in any cycle where `smp_valid` is low.
- R8: After reset, `carrier` is 0 and `rx_data` is 1.
- R9: `smp_data` is a 12-bit two's-complement value, with zero at mid-scale of the input range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | High selects receive; low idles the receive path (transmit mode) |
| smp_valid | input | 1 | Strobe marking a new sample on `smp_data` |
| smp_data | input | SMP_W | Signed sample, two's complement about mid-scale |
| rx_data | output | 1 | Recovered NRZ bit (1 = mark, 1200 Hz) |
| carrier | output | 1 | Carrier present, with amplitude hysteresis |

## Verification
Two kinds of internal fault show up at different times. If the crossing polarity or the interval counter is wrong, `rx_data` goes wrong within two or three half-cycles. Such a fault gives the wrong tone, a flip on a single stray half-cycle, or a response to a small dip. A corrupted block extreme or block counter shows on `carrier` only at a block end, up to 64 valid samples later. While `carrier` is low, it is hidden from `rx_data` altogether. For that reason the bench observes the data decisions only while the amplitude is strong. It checks the carrier thresholds after at least two whole blocks at a steady amplitude.

// File: rtl/fskd_pkg.sv
package fskd_pkg;
  typedef enum logic {
    TONE_SPACE = 1'b0,
    TONE_MARK  = 1'b1
  } tone_e;
endpackage

// File: rtl/fskd_zero_cross.sv
module fskd_zero_cross #(
  parameter int SMP_W   = 12,
  parameter int CNT_W   = 8,
  parameter int ZC_HYST = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_s,
  output logic                    zc_evt,
  output logic [CNT_W-1:0]        interval
);
  localparam logic signed [SMP_W-1:0] HYST_S = SMP_W'(ZC_HYST);

  logic             pol_q;   // 1: signal last seen above +band
  logic [CNT_W-1:0] cnt_q;

  function automatic logic passes_band(input logic pol,
                                       input logic signed [SMP_W-1:0] s);
    if (pol) return s < -HYST_S;
    else     return s > HYST_S;
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == {CNT_W{1'b1}}) ? c : c + 1'b1;
  endfunction

  assign zc_evt   = en && smp_valid && passes_band(pol_q, smp_s);
  assign interval = sat_inc(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      pol_q <= 1'b0;
      cnt_q <= '0;
    end else if (smp_valid) begin
      if (zc_evt) begin
        pol_q <= ~pol_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= sat_inc(cnt_q);
      end
    end
  end

  // R3: polarity only moves on a qualified crossing
  assert_pol_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !zc_evt) |=> $stable(pol_q));
  // R7: nothing advances without a valid sample
  assert_cnt_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !smp_valid) |=> $stable(cnt_q));
endmodule

// File: rtl/fskd_tone_vote.sv
module fskd_tone_vote
  import fskd_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int MARK_MIN = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             meas_stb,
  input  logic [CNT_W-1:0] interval,
  output logic             data_q
);
  localparam logic [CNT_W-1:0] MARK_MIN_L = CNT_W'(MARK_MIN);

  tone_e cls, prev_q;
  logic  have_q;
  logic  agree;

  function automatic tone_e classify(input logic [CNT_W-1:0] n);
    return (n >= MARK_MIN_L) ? TONE_MARK : TONE_SPACE;
  endfunction

  assign cls   = classify(interval);
  assign agree = meas_stb && have_q && (cls == prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      prev_q <= TONE_MARK;
      have_q <= 1'b0;
      data_q <= 1'b1;
    end else if (meas_stb) begin
      prev_q <= cls;
      have_q <= 1'b1;
      if (agree) data_q <= cls;
    end
  end

  // R2: output holds between half-cycle measurements
  assert_vote_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !meas_stb) |=> $stable(data_q));
  // R2: a change needs the previous measurement to agree
  assert_vote_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && meas_stb && !(have_q && cls == prev_q)) |=> $stable(data_q));
endmodule

// File: rtl/fskd_amp_detect.sv
module fskd_amp_detect #(
  parameter int SMP_W    = 12,
  parameter int WIN_LOG2 = 6,
  parameter int CD_ON    = 400,
  parameter int CD_OFF   = 266
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_s,
  output logic                    cd_q
);
  localparam logic [SMP_W:0] ON_L  = (SMP_W+1)'(CD_ON);
  localparam logic [SMP_W:0] OFF_L = (SMP_W+1)'(CD_OFF);

  logic [WIN_LOG2-1:0]     idx_q;
  logic signed [SMP_W-1:0] hi_q, lo_q, hi_n, lo_n;
  logic                    blk_end;
  logic [SMP_W:0]          span;

  function automatic logic [SMP_W:0] swing(input logic signed [SMP_W-1:0] hi,
                                           input logic signed [SMP_W-1:0] lo);
    return {hi[SMP_W-1], hi} - {lo[SMP_W-1], lo};
  endfunction

  always_comb begin
    if (idx_q == '0) begin
      hi_n = smp_s;
      lo_n = smp_s;
    end else begin
      hi_n = (smp_s > hi_q) ? smp_s : hi_q;
      lo_n = (smp_s < lo_q) ? smp_s : lo_q;
    end
  end

  assign blk_end = en && smp_valid && (idx_q == {WIN_LOG2{1'b1}});
  assign span    = swing(hi_n, lo_n);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      idx_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
      cd_q  <= 1'b0;
    end else if (smp_valid) begin
      idx_q <= idx_q + 1'b1;
      hi_q  <= hi_n;
      lo_q  <= lo_n;
      if (blk_end) begin
        if (span > ON_L)       cd_q <= 1'b1;
        else if (span < OFF_L) cd_q <= 1'b0;
      end
    end
  end

  // R4: carrier rises only at a block end with a span over the on limit
  assert_cd_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cd_q) |-> $past(blk_end && span > ON_L));
  // R4/R6: carrier falls only on a small block span or when disabled
  assert_cd_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cd_q) |-> $past(!en || (blk_end && span < OFF_L)));
endmodule

// File: rtl/fsk_demod_cd.sv
module fsk_demod_cd #(
  parameter int SMP_W    = 12,
  parameter int CNT_W    = 8,
  parameter int MARK_MIN = 25,
  parameter int ZC_HYST  = 8,
  parameter int WIN_LOG2 = 6,
  parameter int CD_ON    = 400,
  parameter int CD_OFF   = 266
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  output logic             rx_data,
  output logic             carrier
);
  logic signed [SMP_W-1:0] smp_s;
  logic                    zc_evt;
  logic [CNT_W-1:0]        interval;
  logic                    tone_q;
  logic                    cd_q;

  assign smp_s = smp_data;

  fskd_zero_cross #(.SMP_W(SMP_W), .CNT_W(CNT_W), .ZC_HYST(ZC_HYST)) u_zc (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .smp_valid(smp_valid),
    .smp_s(smp_s), .zc_evt(zc_evt), .interval(interval));

  fskd_tone_vote #(.CNT_W(CNT_W), .MARK_MIN(MARK_MIN)) u_vote (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .meas_stb(zc_evt),
    .interval(interval), .data_q(tone_q));

  fskd_amp_detect #(.SMP_W(SMP_W), .WIN_LOG2(WIN_LOG2),
                    .CD_ON(CD_ON), .CD_OFF(CD_OFF)) u_amp (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .smp_valid(smp_valid),
    .smp_s(smp_s), .cd_q(cd_q));

  assign carrier = cd_q;
  assign rx_data = cd_q ? tone_q : 1'b1;

  // R6: transmit mode idles both outputs on the next clock
  assert_tx_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!carrier && rx_data));
  // R7: no valid sample, no change on either output
  assert_no_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !smp_valid) |=> ($stable(carrier) && $stable(rx_data)));
  // R8: reset state
  assert_reset_R8: assert property (@(posedge clk)
    !rst_n |=> (!carrier && rx_data));
endmodule

// File: tb/fsk_demod_cd_tb.sv
module fsk_demod_cd_tb;
  localparam int SMP_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_en = 1'b1;
  logic             smp_valid = 1'b0;
  logic [SMP_W-1:0] smp_data = '0;
  logic             rx_data, carrier;

  int n_cmp = 0;
  int n_bad = 0;
  int sgn = 1;
  bit done = 1'b0;

  typedef struct {
    string req;
    bit    exp_d;
    bit    exp_c;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  fsk_demod_cd u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .smp_valid(smp_valid),
    .smp_data(smp_data), .rx_data(rx_data), .carrier(carrier));

  // monitor: pops expected items and compares at the following falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_cmp++;
        if (rx_data !== it.exp_d || carrier !== it.exp_c) begin
          n_bad++;
          $display("FAIL %s: rx_data=%0b carrier=%0b expected rx_data=%0b carrier=%0b",
                   it.req, rx_data, carrier, it.exp_d, it.exp_c);
        end
      end
    end
  end

  task automatic expect_out(input string req, input bit d, input bit c);
    item_t it;
    it.req = req; it.exp_d = d; it.exp_c = c;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  // one valid sample, then one invalid cycle carrying a misleading value (R7)
  task automatic send_raw(input int v);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = SMP_W'(v);
    @(negedge clk);
    smp_valid = 1'b0;
    smp_data  = SMP_W'(-v);
  endtask

  task automatic send_n(input int n, input int a);
    for (int i = 0; i < n; i++) send_raw(sgn * a);
  endtask

  task automatic send_half(input int h, input int a);
    send_n(h, a);
    sgn = -sgn;
  endtask

  task automatic tone(input int h, input int a, input int halves);
    for (int i = 0; i < halves; i++) send_half(h, a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_out("R8 reset", 1'b1, 1'b0);

    tone(32, 300, 8);
    expect_out("R1 mark strong", 1'b1, 1'b1);
    expect_out("R4 carrier on", 1'b1, 1'b1);
    tone(17, 300, 8);
    expect_out("R1 space", 1'b0, 1'b1);

    tone(25, 300, 4);
    expect_out("R1 boundary 25 is mark", 1'b1, 1'b1);
    tone(24, 300, 4);
    expect_out("R1 boundary 24 is space", 1'b0, 1'b1);

    tone(32, 300, 4);
    send_half(17, 300);
    send_n(1, 300);
    expect_out("R2 single short half ignored", 1'b1, 1'b1);
    send_n(31, 300); sgn = -sgn;
    send_half(17, 300);
    send_half(17, 300);
    send_n(1, 300);
    expect_out("R2 two short halves switch", 1'b0, 1'b1);
    send_n(31, 300); sgn = -sgn;

    tone(17, 300, 4);
    for (int i = 0; i < 6; i++) begin
      send_n(16, 300);
      send_raw(-sgn * 5);
      send_n(15, 300);
      sgn = -sgn;
    end
    expect_out("R3 small dips ignored", 1'b1, 1'b1);

    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      smp_data = (i % 2 == 0) ? SMP_W'(300) : SMP_W'(-300);
    end
    @(negedge clk);
    smp_data = '0;
    expect_out("R7 invalid cycles ignored", 1'b1, 1'b1);

    tone(32, 160, 8);
    expect_out("R4 mid span holds on", 1'b1, 1'b1);
    tone(17, 100, 16);
    expect_out("R4 weak span off", 1'b1, 1'b0);
    expect_out("R5 no carrier forces mark", 1'b1, 1'b0);
    tone(17, 160, 16);
    expect_out("R4 mid span holds off", 1'b1, 1'b0);
    tone(17, 300, 16);
    expect_out("R9 signed samples strong space", 1'b0, 1'b1);

    rx_en = 1'b0;
    @(negedge clk);
    expect_out("R6 tx idles outputs", 1'b1, 1'b0);
    tone(17, 300, 8);
    expect_out("R6 samples ignored in tx", 1'b1, 1'b0);
    rx_en = 1'b1;
    tone(17, 300, 16);
    expect_out("R6 receive resumes", 1'b0, 1'b1);

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: done=0 expected done=1");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule